// File: doc/BRIEF.md
# Dual Data Pointer with Per-Pointer Count Direction

This block keeps two 16-bit address pointers and a small control byte. The control byte picks which pointer is active, and it holds one count-direction flag for each pointer. All pointer operations act on the active pointer. A load port overwrites the active pointer. A single step strobe moves the active pointer by one. The step goes up or down according to the direction flag that belongs to the pointer selected at that moment.

The surrounding core decodes instructions and performs memory accesses. It writes the control byte through a byte-wide write port and reads it back. It feeds load values and step strobes, and it uses `ptr_q` as the current address. All state changes on the rising clock edge. `ptr_q` and `ctl_rdata` are read combinationally from the stored state, so a change is visible right after the edge that makes it.

Top module: `dptr_unit`

## Requirements
- R1: A synchronous active-high `rst` clears both pointers and the control byte, so `ptr_q` and `ctl_rdata` both read 0000h/00h after the reset edge.
- R2: Control byte layout: bit 0 is the select flag, bit 6 is the down flag of pointer 0, and bit 7 is the down flag of pointer 1. Bits 1 to 5 cannot be stored and always read 0 on `ctl_rdata`.
- R3: `ptr_q` shows pointer 0 when the select flag is 0 and pointer 1 when it is 1.
- R4: With `ld_en` high, `ld_data` is written into the active pointer at the clock edge.
- R5: With `step` high and the active pointer's down flag at 0, the active pointer increases by 1.
- R6: With `step` high and the active pointer's down flag at 1, the active pointer decreases by 1. The down flag of the other pointer has no influence.
- R7: Stepping wraps modulo 2^16: FFFFh up gives 0000h, and 0000h down gives FFFFh.
- R8: The pointer that is not selected keeps its value through any step or load.
- R9: When `ld_en` and `step` are high in the same cycle, the load wins and the step is dropped.
- R10: When a control write and a step or load happen in the same cycle, the pointer operation uses the select and down flags held before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| ctl_we | input | 1 | Control byte write enable |
| ctl_wdata | input | 8 | Control byte write data |
| ctl_rdata | output | 8 | Control byte readback |
| ld_en | input | 1 | Load the active pointer |
| ld_data | input | 16 | Value for the load |
| step | input | 1 | Step the active pointer by one |
| ptr_q | output | 16 | Value of the active pointer |

## Verification
The hardest case to reach is a step that arrives in the same cycle as a control write that changes both the selection and the direction. Only ordering decides which pointer moves and in which direction. The bench first sets up pointer 0 with its down flag set. It then writes a control byte that selects pointer 1 in the very cycle it strobes `step`. It then switches back and confirms that pointer 0 went down while pointer 1 stayed put. The wrap checks drive the pointer to the FFFFh and 0000h edges through a load before stepping.

// File: rtl/dptr_pkg.sv
package dptr_pkg;

    localparam int PTR_W   = 16;
    localparam int CTL_W   = 8;
    localparam int NUM_PTR = 2;

    // Bit positions inside the control byte
    localparam int SEL_BIT   = 0;
    localparam int DOWN0_BIT = 6;
    localparam int DOWN1_BIT = 7;

    localparam logic [CTL_W-1:0] CTL_MASK =
        CTL_W'((1 << SEL_BIT) | (1 << DOWN0_BIT) | (1 << DOWN1_BIT));

    typedef logic [PTR_W-1:0] ptr_t;

    typedef struct packed {
        logic                down1;
        logic                down0;
        logic                sel;
    } ctl_t;

    function automatic logic [CTL_W-1:0] ctl_pack(input ctl_t c);
        logic [CTL_W-1:0] b;
        b            = '0;
        b[SEL_BIT]   = c.sel;
        b[DOWN0_BIT] = c.down0;
        b[DOWN1_BIT] = c.down1;
        return b;
    endfunction

    function automatic ctl_t ctl_unpack(input logic [CTL_W-1:0] b);
        ctl_t c;
        c.sel   = b[SEL_BIT];
        c.down0 = b[DOWN0_BIT];
        c.down1 = b[DOWN1_BIT];
        return c;
    endfunction

    function automatic ptr_t ptr_step(input ptr_t v, input logic down);
        return down ? ptr_t'(v - 1'b1) : ptr_t'(v + 1'b1);
    endfunction

endpackage

// File: rtl/dptr_ctl_reg.sv
module dptr_ctl_reg
    import dptr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [CTL_W-1:0] wdata,
    output ctl_t             ctl,
    output logic [CTL_W-1:0] rdata
);

    ctl_t ctl_r;

    // Bits that cannot be stored are deliberately left unread.
    logic unused_wbits;
    assign unused_wbits = ^(wdata & ~CTL_MASK);

    always_ff @(posedge clk) begin
        if (rst)
            ctl_r <= '0;
        else if (we)
            ctl_r <= ctl_unpack(wdata);
    end

    assign ctl   = ctl_r;
    assign rdata = ctl_pack(ctl_r);

    // R2: bits outside the layout never read as 1
    p_unused_zero_r2: assert property (@(posedge clk) disable iff (rst)
        (rdata & ~CTL_MASK) == '0);

    // R2: a write is reflected in the readback
    p_write_back_r2: assert property (@(posedge clk) disable iff (rst)
        we |=> rdata == ($past(wdata) & CTL_MASK));

endmodule

// File: rtl/dptr_slot.sv
module dptr_slot
    import dptr_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic active,
    input  logic down,
    input  logic ld_en,
    input  ptr_t ld_data,
    input  logic step,
    output ptr_t q
);

    ptr_t q_r;

    always_ff @(posedge clk) begin
        if (rst)
            q_r <= '0;
        else if (active && ld_en)
            q_r <= ld_data;
        else if (active && step)
            q_r <= ptr_step(q_r, down);
    end

    assign q = q_r;

    // R8: a slot that is not selected keeps its value
    p_idle_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !active |=> $stable(q));

endmodule

// File: rtl/dptr_unit.sv
module dptr_unit
    import dptr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             ctl_we,
    input  logic [CTL_W-1:0] ctl_wdata,
    output logic [CTL_W-1:0] ctl_rdata,
    input  logic             ld_en,
    input  logic [PTR_W-1:0] ld_data,
    input  logic             step,
    output logic [PTR_W-1:0] ptr_q
);

    ctl_t ctl;
    ptr_t slot_q [NUM_PTR];
    logic [NUM_PTR-1:0] down_v;
    logic cur_down;

    dptr_ctl_reg u_ctl (
        .clk   (clk),
        .rst   (rst),
        .we    (ctl_we),
        .wdata (ctl_wdata),
        .ctl   (ctl),
        .rdata (ctl_rdata)
    );

    assign down_v = {ctl.down1, ctl.down0};

    for (genvar i = 0; i < NUM_PTR; i++) begin : g_slot
        dptr_slot u_slot (
            .clk     (clk),
            .rst     (rst),
            .active  (ctl.sel == i[0]),
            .down    (down_v[i]),
            .ld_en   (ld_en),
            .ld_data (ld_data),
            .step    (step),
            .q       (slot_q[i])
        );
    end

    assign ptr_q    = slot_q[ctl.sel];
    assign cur_down = down_v[ctl.sel];

    // R1: reset clears everything visible
    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (ptr_q == '0 && ctl_rdata == '0));

    // R4: a load lands in the active pointer
    p_load_r4: assert property (@(posedge clk) disable iff (rst)
        (ld_en && !ctl_we) |=> ptr_q == $past(ld_data));

    // R5: step counts up when the selected pointer's flag is clear
    p_step_up_r5: assert property (@(posedge clk) disable iff (rst)
        (step && !ld_en && !ctl_we && !cur_down) |=>
        ptr_q == PTR_W'($past(ptr_q) + 1'b1));

    // R6: step counts down when the selected pointer's flag is set
    p_step_dn_r6: assert property (@(posedge clk) disable iff (rst)
        (step && !ld_en && !ctl_we && cur_down) |=>
        ptr_q == PTR_W'($past(ptr_q) - 1'b1));

    // R3: with no operation at all, the visible pointer holds
    p_quiet_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (!step && !ld_en && !ctl_we) |=> $stable(ptr_q));

endmodule

// File: tb/dptr_unit_bench.sv
module dptr_unit_bench;

    logic        clk = 1'b0;
    logic        rst;
    logic        ctl_we;
    logic [7:0]  ctl_wdata;
    logic [7:0]  ctl_rdata;
    logic        ld_en;
    logic [15:0] ld_data;
    logic        step;
    logic [15:0] ptr_q;

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;  // 125 MHz

    dptr_unit u_dptr_unit (
        .clk       (clk),
        .rst       (rst),
        .ctl_we    (ctl_we),
        .ctl_wdata (ctl_wdata),
        .ctl_rdata (ctl_rdata),
        .ld_en     (ld_en),
        .ld_data   (ld_data),
        .step      (step),
        .ptr_q     (ptr_q)
    );

    // Vector: op[41:40] (0 ctl write, 1 load, 2 step), data[39:24],
    // expected pointer[23:8], expected control readback[7:0]
    localparam int NV = 15;
    localparam logic [41:0] VEC [NV] = '{
        {2'd0, 16'h0000, 16'h0000, 8'h00},
        {2'd1, 16'h1234, 16'h1234, 8'h00},
        {2'd2, 16'h0000, 16'h1235, 8'h00},
        {2'd0, 16'h0001, 16'h0000, 8'h01},
        {2'd1, 16'hABCD, 16'hABCD, 8'h01},
        {2'd2, 16'h0000, 16'hABCE, 8'h01},
        {2'd0, 16'h0081, 16'hABCE, 8'h81},
        {2'd2, 16'h0000, 16'hABCD, 8'h81},
        {2'd0, 16'h0080, 16'h1235, 8'h80},
        {2'd2, 16'h0000, 16'h1236, 8'h80},
        {2'd0, 16'h00FF, 16'hABCD, 8'hC1},
        {2'd2, 16'h0000, 16'hABCC, 8'hC1},
        {2'd0, 16'h0040, 16'h1236, 8'h40},
        {2'd2, 16'h0000, 16'h1235, 8'h40},
        {2'd0, 16'h0001, 16'hABCC, 8'h01}
    };

    task automatic cyc(input bit we, input logic [7:0] wd,
                       input bit ld, input logic [15:0] ldd, input bit st);
        @(negedge clk);
        ctl_we = we; ctl_wdata = wd; ld_en = ld; ld_data = ldd; step = st;
        @(posedge clk);
        #1;
        ctl_we = 1'b0; ld_en = 1'b0; step = 1'b0;
    endtask

    task automatic chk(input string req, input logic [15:0] ep, input logic [7:0] ec);
        checks++;
        if (ptr_q !== ep || ctl_rdata !== ec) begin
            failures++;
            $display("FAIL %s: ptr_q=%h ctl_rdata=%h expected ptr_q=%h ctl_rdata=%h",
                     req, ptr_q, ctl_rdata, ep, ec);
        end
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; ctl_we = 0; ctl_wdata = 0; ld_en = 0; ld_data = 0; step = 0;
        repeat (3) @(posedge clk);
        #1;
        rst = 1'b0;
        chk("R1 reset state", 16'h0000, 8'h00);

        // Table walk: R2 R3 R4 R5 R6 R8
        for (int i = 0; i < NV; i++) begin
            logic [1:0] op;
            op = VEC[i][41:40];
            cyc(op == 2'd0, VEC[i][31:24], op == 2'd1, VEC[i][39:24], op == 2'd2);
            chk($sformatf("R2/R3/R4/R5/R6/R8 vector %0d", i), VEC[i][23:8], VEC[i][7:0]);
        end

        // R7: wrap up and down on pointer 0
        cyc(1, 8'h00, 0, 0, 0);
        cyc(0, 0, 1, 16'hFFFF, 0);
        cyc(0, 0, 0, 0, 1);
        chk("R7 wrap up", 16'h0000, 8'h00);
        cyc(1, 8'h40, 0, 0, 0);
        cyc(0, 0, 0, 0, 1);
        chk("R7 wrap down", 16'hFFFF, 8'h40);

        // R9: load beats step
        cyc(0, 0, 1, 16'h0010, 1);
        chk("R9 load over step", 16'h0010, 8'h40);

        // R10: control write with step in same cycle uses old flags
        cyc(1, 8'h01, 0, 0, 1);
        chk("R10 new select shown, pointer 1 untouched", 16'hABCC, 8'h01);
        cyc(1, 8'h00, 0, 0, 0);
        chk("R10 pointer 0 stepped down with old flags", 16'h000F, 8'h00);

        // R8: a load on pointer 0 leaves pointer 1 alone
        cyc(0, 0, 1, 16'h7777, 0);
        cyc(1, 8'h01, 0, 0, 0);
        chk("R8 inactive pointer kept through load", 16'hABCC, 8'h01);

        // R1: reset in mid-run clears both pointers and control
        @(negedge clk); rst = 1'b1;
        @(posedge clk); #1; rst = 1'b0;
        chk("R1 reset mid-run", 16'h0000, 8'h00);
        cyc(1, 8'h01, 0, 0, 0);
        chk("R1 pointer 1 cleared", 16'h0000, 8'h01);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule